// File: doc/BRIEF.md
# Control and Status Register Bank

This block sits between a simple register-access port (address, write enable, write data, registered read data) and the logic of one core. It provides two kinds of register. A pass-through register forwards each bus write to the core as a data word with a one-cycle strobe, and returns on reads whatever value the core drives. A stored register is built from fields that the block keeps in flops. Each field has one access policy for the bus side and another for the core side.

The stored register in this configuration is 18 bits wide. That is wider than the 8-bit bus word, so it is cut into three words at consecutive addresses, with the most significant word first. The core sees every field it may read on one flat output vector. It loads any field it may write through a per-field strobe and a flat data vector. The field table lives in a package, so a different layout means editing a single function.

Top module: `csr_bank`

## Requirements
- R1: A bus write to address 0 (the pass-through register) drives `raw_wstb` high for exactly the one cycle after the write edge, with `raw_wdata` equal to the low 6 bits of the written word. `raw_wstb` is low in every other cycle.
- R2: A bus read of address 0 returns, one cycle after the address is presented, the value on `raw_rdata` sampled at that edge, zero-extended to 8 bits.
- R3: The stored register has four fields, with bits given as [msb:lsb] and policies given as bus/core:
  - F0 at [3:0] is read-write on the bus and read-only for the core.
  - F1 at [9:4] is read-only on the bus and write-only for the core.
  - F2 at [14:10] is read-write on both sides.
  - F3 at [17:15] is write-only on the bus and read-only for the core.
  Address 1 carries bits [23:16] (bits above 17 are zero), address 2 carries bits [15:8], and address 3 carries bits [7:0].
- R4: A bus write to a stored-register address updates only the bus-writable field bits inside that word. Bits of bus-read-only fields, and every bit outside the addressed word, keep their values.
- R5: A bus read of a stored-register address returns that word one cycle later. Bits of bus-write-only fields read as zero.
- R6: `fld_q` shows at all times the stored value of every core-readable field, at that field's bit positions. The bits of fields the core cannot read are zero.
- R7: When `fld_we[i]` is high at a clock edge and field i is core-writable, field i loads its bits of `fld_d`. For a field that is core-read-only, the strobe has no effect.
- R8: If the core and the bus write the same field at the same edge, the field takes the core's value in full.
- R9: Reads of addresses 4 to 15 return zero, and writes to them change no field and raise no strobe.
- R10: While `rst` is high at a clock edge, all field storage, `raw_wstb`, `raw_wdata` and `csr_rdata` clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 4 | Register word address |
| csr_we | input | 1 | Bus write enable |
| csr_wdata | input | 8 | Bus write data |
| csr_rdata | output | 8 | Bus read data, valid one cycle after the address |
| raw_wdata | output | 6 | Data of the last bus write to the pass-through register |
| raw_wstb | output | 1 | One-cycle strobe marking `raw_wdata` valid |
| raw_rdata | input | 6 | Core value returned on reads of the pass-through register |
| fld_d | input | 18 | Core write data, laid out as in the stored register |
| fld_we | input | 4 | Per-field core write strobes, bit i for field Fi |
| fld_q | output | 18 | Core view of core-readable fields |

## Verification
The assertions cover these properties on every cycle:
- the pass-through strobe and its data;
- the read latency of the pass-through word;
- zero reads of unmapped addresses and of bus-write-only bits;
- zero bits of `fld_q` wherever the core has no read access;
- the core taking a core-writable field's value at once;
- core-read-only fields holding still while the bus is idle.

Only the bench scenarios show the rest:
- the most-significant-word-first placement, with a distinct pattern written to each word;
- bus writes dropped on bus-read-only bits;
- the core winning a same-edge collision;
- unmapped writes leaving the fields unchanged.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

    typedef enum logic [1:0] {
        ACC_RO = 2'd0,
        ACC_WO = 2'd1,
        ACC_RW = 2'd2
    } acc_e;

    typedef struct packed {
        int   width;
        acc_e bus;
        acc_e dev;
    } fld_desc_t;

    localparam int NFIELDS = 4;

    // Field table, least significant field first; fields tile the register.
    function automatic fld_desc_t fld_desc(input int idx);
        fld_desc_t d;
        case (idx)
            0:       d = '{width: 4, bus: ACC_RW, dev: ACC_RO};
            1:       d = '{width: 6, bus: ACC_RO, dev: ACC_WO};
            2:       d = '{width: 5, bus: ACC_RW, dev: ACC_RW};
            default: d = '{width: 3, bus: ACC_WO, dev: ACC_RO};
        endcase
        return d;
    endfunction

    function automatic int fld_lsb(input int idx);
        int pos;
        pos = 0;
        for (int f = 0; f < idx; f++) pos += fld_desc(f).width;
        return pos;
    endfunction

    function automatic int reg_width();
        return fld_lsb(NFIELDS);
    endfunction

    localparam int REG_W = reg_width();

    function automatic bit acc_can_wr(input acc_e a);
        return a != ACC_RO;
    endfunction

    function automatic bit acc_can_rd(input acc_e a);
        return a != ACC_WO;
    endfunction

    // Bit mask of the register bits one side may read or write.
    function automatic logic [REG_W-1:0] policy_mask(input bit dev_side, input bit wr);
        logic [REG_W-1:0] m;
        fld_desc_t        d;
        acc_e             a;
        bit               ok;
        int               base;
        m = '0;
        for (int f = 0; f < NFIELDS; f++) begin
            d    = fld_desc(f);
            base = fld_lsb(f);
            a    = dev_side ? d.dev : d.bus;
            ok   = wr ? acc_can_wr(a) : acc_can_rd(a);
            for (int b = 0; b < d.width; b++)
                if (ok) m[base + b] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [REG_W-1:0] BUS_RD_MASK = policy_mask(1'b0, 1'b0);
    localparam logic [REG_W-1:0] DEV_RD_MASK = policy_mask(1'b1, 1'b0);

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode #(
    parameter int ADDR_W   = 4,
    parameter int RAW_ADDR = 0,
    parameter int MGD_BASE = 1,
    parameter int NWORDS   = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              raw_hit,
    output logic [NWORDS-1:0] word_hit
);
    assign raw_hit = (addr == ADDR_W'(RAW_ADDR));

    for (genvar k = 0; k < NWORDS; k++) begin : g_word
        assign word_hit[k] = (addr == ADDR_W'(MGD_BASE + k));
    end
endmodule

// File: rtl/csr_raw_port.sv
module csr_raw_port #(
    parameter int RAW_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_we,
    input  logic [RAW_W-1:0] wdata,
    output logic [RAW_W-1:0] raw_wdata,
    output logic             raw_wstb
);
    always_ff @(posedge clk) begin
        if (rst) begin
            raw_wstb  <= 1'b0;
            raw_wdata <= '0;
        end else begin
            raw_wstb <= hit_we;
            if (hit_we) raw_wdata <= wdata;
        end
    end
endmodule

// File: rtl/csr_field.sv
module csr_field #(
    parameter int W      = 1,
    parameter bit BUS_WR = 1'b1,
    parameter bit DEV_WR = 1'b1,
    parameter bit DEV_RD = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] bus_en,
    input  logic [W-1:0] bus_d,
    input  logic         dev_we,
    input  logic [W-1:0] dev_d,
    output logic [W-1:0] q,
    output logic [W-1:0] dev_q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (DEV_WR && dev_we)
            q <= dev_d;
        else if (BUS_WR)
            q <= (q & ~bus_en) | (bus_d & bus_en);
    end

    assign dev_q = DEV_RD ? q : '0;
endmodule

// File: rtl/csr_bank.sv
module csr_bank
    import csr_bank_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int RAW_W    = 6,
    parameter int RAW_ADDR = 0,
    parameter int MGD_BASE = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  csr_addr,
    input  logic               csr_we,
    input  logic [DATA_W-1:0]  csr_wdata,
    output logic [DATA_W-1:0]  csr_rdata,
    output logic [RAW_W-1:0]   raw_wdata,
    output logic               raw_wstb,
    input  logic [RAW_W-1:0]   raw_rdata,
    input  logic [REG_W-1:0]   fld_d,
    input  logic [NFIELDS-1:0] fld_we,
    output logic [REG_W-1:0]   fld_q
);
    localparam int NWORDS = (REG_W + DATA_W - 1) / DATA_W;
    localparam int PAD_W  = NWORDS * DATA_W;

    logic              raw_hit;
    logic [NWORDS-1:0] word_hit;
    logic [PAD_W-1:0]  wen_pad;
    logic [PAD_W-1:0]  wdat_pad;
    logic [PAD_W-1:0]  rd_pad;
    logic [REG_W-1:0]  store;
    logic [DATA_W-1:0] rd_next;

    csr_addr_decode #(
        .ADDR_W  (ADDR_W),
        .RAW_ADDR(RAW_ADDR),
        .MGD_BASE(MGD_BASE),
        .NWORDS  (NWORDS)
    ) u_dec (
        .addr    (csr_addr),
        .raw_hit (raw_hit),
        .word_hit(word_hit)
    );

    csr_raw_port #(.RAW_W(RAW_W)) u_raw (
        .clk      (clk),
        .rst      (rst),
        .hit_we   (csr_we & raw_hit),
        .wdata    (csr_wdata[RAW_W-1:0]),
        .raw_wdata(raw_wdata),
        .raw_wstb (raw_wstb)
    );

    // Word k (address MGD_BASE+k) maps to the k-th word counted from the top.
    for (genvar k = 0; k < NWORDS; k++) begin : g_slice
        assign wen_pad [(NWORDS-1-k)*DATA_W +: DATA_W] = {DATA_W{csr_we & word_hit[k]}};
        assign wdat_pad[(NWORDS-1-k)*DATA_W +: DATA_W] = csr_wdata;
    end

    for (genvar g = 0; g < NFIELDS; g++) begin : g_fld
        localparam fld_desc_t D   = fld_desc(g);
        localparam int        LSB = fld_lsb(g);
        csr_field #(
            .W     (D.width),
            .BUS_WR(acc_can_wr(D.bus)),
            .DEV_WR(acc_can_wr(D.dev)),
            .DEV_RD(acc_can_rd(D.dev))
        ) u_fld (
            .clk   (clk),
            .rst   (rst),
            .bus_en(wen_pad[LSB +: D.width]),
            .bus_d (wdat_pad[LSB +: D.width]),
            .dev_we(fld_we[g]),
            .dev_d (fld_d[LSB +: D.width]),
            .q     (store[LSB +: D.width]),
            .dev_q (fld_q[LSB +: D.width])
        );
    end

    assign rd_pad = PAD_W'(store & BUS_RD_MASK);

    always_comb begin
        rd_next = '0;
        if (raw_hit) rd_next = DATA_W'(raw_rdata);
        for (int k = 0; k < NWORDS; k++)
            if (word_hit[k]) rd_next = rd_next | rd_pad[(NWORDS-1-k)*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk) begin
        if (rst) csr_rdata <= '0;
        else     csr_rdata <= rd_next;
    end
endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk
    import csr_bank_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int RAW_W    = 6,
    parameter int RAW_ADDR = 0,
    parameter int MGD_BASE = 1
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  csr_addr,
    input logic               csr_we,
    input logic [RAW_W-1:0]   wdata_lo,
    input logic [DATA_W-1:0]  csr_rdata,
    input logic [RAW_W-1:0]   raw_wdata,
    input logic               raw_wstb,
    input logic [RAW_W-1:0]   raw_rdata,
    input logic [REG_W-1:0]   fld_d,
    input logic [NFIELDS-1:0] fld_we,
    input logic [REG_W-1:0]   fld_q
);
    localparam int NWORDS = (REG_W + DATA_W - 1) / DATA_W;
    localparam int PAD_W  = NWORDS * DATA_W;
    localparam logic [PAD_W-1:0] RD_PAD = PAD_W'(BUS_RD_MASK);

    logic raw_sel, mapped;
    assign raw_sel = (csr_addr == ADDR_W'(RAW_ADDR));
    assign mapped  = raw_sel ||
                     ((int'(csr_addr) >= MGD_BASE) && (int'(csr_addr) < MGD_BASE + NWORDS));

    assert_raw_strobe_R1: assert property (@(posedge clk) disable iff (rst)
        (csr_we && raw_sel) |=> (raw_wstb && raw_wdata == $past(wdata_lo)));

    assert_raw_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !(csr_we && raw_sel) |=> !raw_wstb);

    assert_raw_read_R2: assert property (@(posedge clk) disable iff (rst)
        raw_sel |=> (csr_rdata == DATA_W'($past(raw_rdata))));

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !mapped |=> (csr_rdata == '0));

    assert_devq_mask_R6: assert property (@(posedge clk) disable iff (rst)
        (fld_q & ~DEV_RD_MASK) == '0);

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (fld_q == '0 && !raw_wstb && csr_rdata == '0));

    for (genvar k = 0; k < NWORDS; k++) begin : g_wo
        localparam logic [DATA_W-1:0] WMASK = RD_PAD[(NWORDS-1-k)*DATA_W +: DATA_W];
        assert_wo_zero_R5: assert property (@(posedge clk) disable iff (rst)
            (csr_addr == ADDR_W'(MGD_BASE + k)) |=> ((csr_rdata & ~WMASK) == '0));
    end

    for (genvar g = 0; g < NFIELDS; g++) begin : g_fchk
        localparam fld_desc_t D   = fld_desc(g);
        localparam int        LSB = fld_lsb(g);
        if (acc_can_wr(D.dev) && acc_can_rd(D.dev)) begin : g_rw
            assert_dev_load_R8: assert property (@(posedge clk) disable iff (rst)
                fld_we[g] |=> (fld_q[LSB +: D.width] == $past(fld_d[LSB +: D.width])));
        end else if (acc_can_rd(D.dev)) begin : g_ro
            assert_dev_ro_hold_R7: assert property (@(posedge clk) disable iff (rst)
                !csr_we |=> $stable(fld_q[LSB +: D.width]));
        end
    end
endmodule

bind csr_bank csr_bank_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .RAW_W   (RAW_W),
    .RAW_ADDR(RAW_ADDR),
    .MGD_BASE(MGD_BASE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .csr_addr (csr_addr),
    .csr_we   (csr_we),
    .wdata_lo (csr_wdata[RAW_W-1:0]),
    .csr_rdata(csr_rdata),
    .raw_wdata(raw_wdata),
    .raw_wstb (raw_wstb),
    .raw_rdata(raw_rdata),
    .fld_d    (fld_d),
    .fld_we   (fld_we),
    .fld_q    (fld_q)
);

// File: tb/csr_bank_tb.sv
module csr_bank_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  csr_addr = '0;
    logic        csr_we = 1'b0;
    logic [7:0]  csr_wdata = '0;
    logic [7:0]  csr_rdata;
    logic [5:0]  raw_wdata;
    logic        raw_wstb;
    logic [5:0]  raw_rdata = '0;
    logic [17:0] fld_d = '0;
    logic [3:0]  fld_we = '0;
    logic [17:0] fld_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    csr_bank u_dut (
        .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .raw_wdata(raw_wdata),
        .raw_wstb(raw_wstb), .raw_rdata(raw_rdata), .fld_d(fld_d),
        .fld_we(fld_we), .fld_q(fld_q)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        csr_addr = a; csr_wdata = d; csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        csr_addr = a; csr_we = 1'b0;
        @(negedge clk);
        d = csr_rdata;
    endtask

    task automatic dev_pulse(input logic [3:0] we, input logic [17:0] d);
        @(negedge clk);
        fld_d = d; fld_we = we;
        @(negedge clk);
        fld_we = '0;
    endtask

    task automatic t_reset();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R10 rdata", 32'(csr_rdata), 32'h0);
        chk("R10 strobe", 32'(raw_wstb), 32'h0);
        chk("R10 fld_q", 32'(fld_q), 32'h0);
    endtask

    task automatic t_layout();
        logic [7:0] r;
        bus_write(4'd3, 8'hA5);
        bus_write(4'd2, 8'h96);
        bus_write(4'd1, 8'h03);
        chk("R4 fld_q after word writes", 32'(fld_q), 32'h39405);
        bus_read(4'd1, r); chk("R3 top word", 32'(r), 32'h00);
        bus_read(4'd2, r); chk("R5 middle word", 32'(r), 32'h14);
        bus_read(4'd3, r); chk("R3 low word", 32'(r), 32'h05);
    endtask

    task automatic t_dev_write();
        logic [7:0] r;
        dev_pulse(4'b0010, 18'h002A0);
        chk("R6 wo field hidden", 32'(fld_q), 32'h39405);
        bus_read(4'd3, r); chk("R7 dev write low", 32'(r), 32'hA5);
        bus_read(4'd2, r); chk("R7 dev write mid", 32'(r), 32'h16);
    endtask

    task automatic t_dev_ro_ignored();
        dev_pulse(4'b0001, 18'h0000C);
        chk("R7 ro strobe ignored", 32'(fld_q), 32'h39405);
    endtask

    task automatic t_collision();
        logic [7:0] r;
        @(negedge clk);
        csr_addr = 4'd2; csr_wdata = 8'h7C; csr_we = 1'b1;
        fld_d = 18'h02400; fld_we = 4'b0100;
        @(negedge clk);
        csr_we = 1'b0; fld_we = '0;
        chk("R8 device wins", 32'(fld_q), 32'h32405);
        bus_read(4'd2, r); chk("R8 mid word", 32'(r), 32'h26);
        bus_read(4'd3, r); chk("R4 low word untouched", 32'(r), 32'hA5);
        bus_read(4'd1, r); chk("R5 wo bits zero", 32'(r), 32'h00);
    endtask

    task automatic t_raw_write();
        @(negedge clk);
        csr_addr = 4'd0; csr_wdata = 8'hEB; csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0;
        chk("R1 strobe high", 32'(raw_wstb), 32'h1);
        chk("R1 data", 32'(raw_wdata), 32'h2B);
        @(negedge clk);
        chk("R1 strobe one cycle", 32'(raw_wstb), 32'h0);
        chk("R4 raw leaves fields", 32'(fld_q), 32'h32405);
    endtask

    task automatic t_raw_read();
        logic [7:0] r;
        raw_rdata = 6'h15;
        bus_read(4'd0, r); chk("R2 raw read", 32'(r), 32'h15);
        raw_rdata = 6'h3F;
        bus_read(4'd0, r); chk("R2 raw read follows core", 32'(r), 32'h3F);
    endtask

    task automatic t_unmapped();
        logic [7:0] r;
        @(negedge clk);
        csr_addr = 4'd9; csr_wdata = 8'hFF; csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0;
        chk("R9 no strobe", 32'(raw_wstb), 32'h0);
        chk("R9 fields kept", 32'(fld_q), 32'h32405);
        bus_read(4'd7, r);  chk("R9 read 7", 32'(r), 32'h00);
        bus_read(4'd15, r); chk("R9 read 15", 32'(r), 32'h00);
    endtask

    task automatic t_reset_mid();
        logic [7:0] r;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R10 fields cleared", 32'(fld_q), 32'h0);
        bus_read(4'd3, r); chk("R10 low word cleared", 32'(r), 32'h00);
        bus_read(4'd2, r); chk("R10 mid word cleared", 32'(r), 32'h00);
    endtask

    initial begin
        t_reset();
        t_layout();
        t_dev_write();
        t_dev_ro_ignored();
        t_collision();
        t_raw_write();
        t_raw_read();
        t_unmapped();
        t_reset_mid();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule